// File: doc/BRIEF.md
# Dual-Channel Slave-FIFO Loopback Engine

This block sits on the 16-bit synchronous slave-FIFO port of a USB bridge controller. It runs in the single 25 MHz clock domain that it shares with the bridge. It pulls host-to-device packets out of two OUT endpoints and parks each packet in a local word buffer of its own. It then pushes the same words back out on the paired IN endpoint. The pairings are fixed: endpoint 2 to endpoint 6, and endpoint 4 to endpoint 8. Each local buffer holds 512 bytes, which is 256 bus words and exactly one full-size bridge packet.

One controller shares the port between the two channels, alternating between them and moving one packet at a time. For each packet the controller runs through six states:

- SETTLE_OUT selects the OUT endpoint and clears the buffer.
- PRIME raises output-enable.
- DRAIN reads words while the bridge reports data.
- SETTLE_IN selects the paired IN endpoint.
- FILL writes the words back while the bridge has room.
- COMMIT pulses packet-end for a short packet.

The transitions are:

- SETTLE_OUT→PRIME, PRIME→DRAIN and SETTLE_IN→FILL are unconditional.
- DRAIN→SETTLE_IN happens on the 256th word, or when the endpoint runs empty with data already held.
- DRAIN→SETTLE_OUT, with the channel toggled, happens when the endpoint is empty and no word was taken.
- FILL→COMMIT happens on the last write of a short packet.
- FILL→SETTLE_OUT, with the channel toggled, happens on the last write of a full packet.
- COMMIT→SETTLE_OUT, with the channel toggled, is unconditional.

The tri-state data pad lives outside the block. The block hands it separate input, output and drive-enable signals.

Top module: `usb_fifo_echo`

## Requirements
- R1: While reset is held, the endpoint select is 00 and the read, write, output-enable, packet-end and bus-drive outputs are all low.
- R2: A local buffer never accepts more than 256 words. A 256-word packet is echoed in full, and packet-end is not pulsed for it.
- R3: The read strobe is asserted only while an OUT endpoint (select 00 or 01) is addressed and its empty flag is low.
- R4: Every read strobe is preceded in the previous cycle by output-enable.
- R5: The write strobe is asserted only while an IN endpoint (select 10 or 11) is addressed and its full flag is low.
- R6: The bus-drive enable is high exactly in the cycles in which the write strobe is high.
- R7: Words read from select 00 (endpoint 2) come back on select 10 (endpoint 6), and words read from select 01 (endpoint 4) come back on select 11 (endpoint 8). Each stream keeps its values and its order.
- R8: In any cycle in which the endpoint select differs from its value in the previous cycle, no strobe is asserted.
- R9: A packet of 1 to 255 words gets exactly one packet-end pulse. The pulse is addressed to its IN endpoint and comes after the last of its words has been written. An empty OUT endpoint produces no writes and no pulse.
- R10: The channels are served alternately and one packet at a time. When both channels hold a packet, the second one's first read comes after the first one's last write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | 25 MHz clock shared with the bridge |
| rst_n | input | 1 | Active-low synchronous reset |
| ep_sel | output | 2 | Endpoint select: 00=EP2, 01=EP4, 10=EP6, 11=EP8 |
| rd_stb | output | 1 | Read strobe, pops one word from the addressed OUT endpoint |
| wr_stb | output | 1 | Write strobe, pushes one word into the addressed IN endpoint |
| oe_stb | output | 1 | Output-enable, asks the bridge to drive the bus |
| pkt_end | output | 1 | Packet-end pulse, commits a short IN packet |
| flag_empty | input | 1 | Addressed OUT endpoint has no data |
| flag_full | input | 1 | Addressed IN endpoint has no room |
| bus_in | input | 16 | Data from the pad (driven by the bridge) |
| bus_out | output | 16 | Data to the pad during writes |
| bus_oe | output | 1 | Pad drive enable; the pad is tri-stated when low |

## Verification
The assertions assume that the empty and full flags describe whichever endpoint is addressed at the moment. They also assume that the bridge never ends an OUT stream in the middle of a packet, so each empty flag marks a packet boundary. The stimulus respects this by loading each OUT endpoint with one whole packet per round and loading more only once both echoes are done. Full-flag backpressure is drawn at random every cycle. Lengths come from a fixed seed and are mixed with directed cases of 0, 1, 255 and 256 words.

// File: rtl/usb_echo_pkg.sv
package usb_echo_pkg;

    typedef enum logic [2:0] {
        ST_SETTLE_OUT,
        ST_PRIME,
        ST_DRAIN,
        ST_SETTLE_IN,
        ST_FILL,
        ST_COMMIT
    } echo_state_t;

    // Endpoint select: MSB picks direction (0 = OUT, 1 = IN), LSB picks channel.
    function automatic logic [1:0] out_ep(input logic ch);
        return {1'b0, ch};
    endfunction

    function automatic logic [1:0] in_ep(input logic ch);
        return {1'b1, ch};
    endfunction

endpackage

// File: rtl/echo_buffer.sv
module echo_buffer #(
    parameter int WIDTH = 16,
    parameter int DEPTH = 256
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             push,
    input  logic [WIDTH-1:0] push_data,
    input  logic             pop,
    output logic [WIDTH-1:0] head_data,
    output logic             full
);
    localparam int AW = $clog2(DEPTH);

    logic [WIDTH-1:0] mem [DEPTH];
    logic [AW:0]      wr_ptr;
    logic [AW:0]      rd_ptr;

    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
        end else begin
            if (push) wr_ptr <= wr_ptr + 1'b1;
            if (pop)  rd_ptr <= rd_ptr + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (push) mem[wr_ptr[AW-1:0]] <= push_data;
    end

    assign head_data = mem[rd_ptr[AW-1:0]];
    assign full      = (wr_ptr == (AW+1)'(DEPTH));

    // R2: the buffer never takes a word beyond one full packet
    p_no_overflow_r2: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> (wr_ptr < (AW+1)'(DEPTH)))
        else $error("buffer overflow");

    // R7: a word is sent back only after it was stored
    p_no_underflow_r7: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> (rd_ptr < wr_ptr))
        else $error("buffer underflow");

endmodule

// File: rtl/echo_ctrl.sv
module echo_ctrl
    import usb_echo_pkg::*;
#(
    parameter int DEPTH = 256
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       flag_empty,
    input  logic       flag_full,
    input  logic       buf_full,
    output logic       chan,
    output logic [1:0] ep_sel,
    output logic       rd_stb,
    output logic       wr_stb,
    output logic       oe_stb,
    output logic       pkt_end,
    output logic       buf_clear
);
    localparam int CW = $clog2(DEPTH + 1);

    echo_state_t   state_q, state_d;
    logic          chan_q, chan_d;
    logic [CW-1:0] len_q;
    logic [CW-1:0] sent_q;

    // State register and packet counters
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_SETTLE_OUT;
            chan_q  <= 1'b0;
            len_q   <= '0;
            sent_q  <= '0;
        end else begin
            state_q <= state_d;
            chan_q  <= chan_d;
            if (state_q == ST_SETTLE_OUT) len_q <= '0;
            else if (rd_stb)              len_q <= len_q + 1'b1;
            if (state_q == ST_SETTLE_IN)  sent_q <= '0;
            else if (wr_stb)              sent_q <= sent_q + 1'b1;
        end
    end

    // Outputs and next state
    always_comb begin
        state_d   = state_q;
        chan_d    = chan_q;
        ep_sel    = out_ep(chan_q);
        rd_stb    = 1'b0;
        wr_stb    = 1'b0;
        oe_stb    = 1'b0;
        pkt_end   = 1'b0;
        buf_clear = 1'b0;
        unique case (state_q)
            ST_SETTLE_OUT: begin
                buf_clear = 1'b1;
                state_d   = ST_PRIME;
            end
            ST_PRIME: begin
                oe_stb  = 1'b1;
                state_d = ST_DRAIN;
            end
            ST_DRAIN: begin
                oe_stb = 1'b1;
                rd_stb = !flag_empty && !buf_full;
                if (rd_stb && (len_q == CW'(DEPTH - 1))) begin
                    state_d = ST_SETTLE_IN;
                end else if (flag_empty || buf_full) begin
                    if (len_q == '0) begin
                        state_d = ST_SETTLE_OUT;
                        chan_d  = ~chan_q;
                    end else begin
                        state_d = ST_SETTLE_IN;
                    end
                end
            end
            ST_SETTLE_IN: begin
                ep_sel  = in_ep(chan_q);
                state_d = ST_FILL;
            end
            ST_FILL: begin
                ep_sel = in_ep(chan_q);
                wr_stb = !flag_full;
                if (wr_stb && (sent_q == len_q - 1'b1)) begin
                    if (len_q == CW'(DEPTH)) begin
                        state_d = ST_SETTLE_OUT;
                        chan_d  = ~chan_q;
                    end else begin
                        state_d = ST_COMMIT;
                    end
                end
            end
            ST_COMMIT: begin
                ep_sel  = in_ep(chan_q);
                pkt_end = 1'b1;
                state_d = ST_SETTLE_OUT;
                chan_d  = ~chan_q;
            end
            default: state_d = ST_SETTLE_OUT;
        endcase
    end

    assign chan = chan_q;

    // R3: reads only from a non-empty OUT endpoint
    p_rd_gated_r3: assert property (@(posedge clk) disable iff (!rst_n)
        rd_stb |-> (!flag_empty && !ep_sel[1]))
        else $error("read while empty");

    // R4: output-enable leads every read by a cycle
    p_oe_leads_r4: assert property (@(posedge clk) disable iff (!rst_n)
        rd_stb |-> $past(oe_stb))
        else $error("read without prior output-enable");

    // R5: writes only into an IN endpoint with room
    p_wr_gated_r5: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stb |-> (!flag_full && ep_sel[1]))
        else $error("write while full");

    // R8: an address change cycle carries no strobe
    p_settle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(ep_sel) |-> !(rd_stb || wr_stb || oe_stb || pkt_end))
        else $error("strobe on address change");

    // R9: packet-end is a single pulse following a write
    p_commit_after_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
        pkt_end |-> ($past(wr_stb) && ep_sel[1]))
        else $error("packet-end not after a write");

    p_commit_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
        pkt_end |=> !pkt_end)
        else $error("packet-end longer than one cycle");

    // R10: every return to the OUT side moves to the other channel
    p_alternate_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SETTLE_OUT && $past(state_q) != ST_SETTLE_OUT) |-> (chan_q != $past(chan_q)))
        else $error("channel not alternated");

endmodule

// File: rtl/usb_fifo_echo.sv
module usb_fifo_echo #(
    parameter int BUS_W      = 16,
    parameter int FIFO_BYTES = 512
) (
    input  logic             clk,
    input  logic             rst_n,
    output logic [1:0]       ep_sel,
    output logic             rd_stb,
    output logic             wr_stb,
    output logic             oe_stb,
    output logic             pkt_end,
    input  logic             flag_empty,
    input  logic             flag_full,
    input  logic [BUS_W-1:0] bus_in,
    output logic [BUS_W-1:0] bus_out,
    output logic             bus_oe
);
    localparam int DEPTH = FIFO_BYTES / (BUS_W / 8);
    localparam int NCH   = 2;

    logic             chan;
    logic             buf_clear;
    logic [BUS_W-1:0] head_v [NCH];
    logic             full_v [NCH];

    echo_ctrl #(.DEPTH(DEPTH)) i_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .flag_empty (flag_empty),
        .flag_full  (flag_full),
        .buf_full   (full_v[chan]),
        .chan       (chan),
        .ep_sel     (ep_sel),
        .rd_stb     (rd_stb),
        .wr_stb     (wr_stb),
        .oe_stb     (oe_stb),
        .pkt_end    (pkt_end),
        .buf_clear  (buf_clear)
    );

    for (genvar g = 0; g < NCH; g++) begin : g_chan
        logic sel;
        assign sel = (chan == 1'(g));
        echo_buffer #(.WIDTH(BUS_W), .DEPTH(DEPTH)) i_buf (
            .clk       (clk),
            .rst_n     (rst_n),
            .clear     (buf_clear && sel),
            .push      (rd_stb && sel),
            .push_data (bus_in),
            .pop       (wr_stb && sel),
            .head_data (head_v[g]),
            .full      (full_v[g])
        );
    end

    assign bus_out = head_v[chan];
    assign bus_oe  = wr_stb;

    // R6: the pad is driven only toward an IN endpoint
    p_drive_in_only_r6: assert property (@(posedge clk) disable iff (!rst_n)
        bus_oe |-> (ep_sel[1] && !oe_stb))
        else $error("bus driven outside an IN write");

endmodule

// File: tb/test_usb_fifo_echo.sv
module test_usb_fifo_echo;
    localparam int CLK_PERIOD = 40;
    localparam int MEMW       = 2048;
    localparam int DEPTH      = 256;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  ep_sel;
    logic        rd_stb, wr_stb, oe_stb, pkt_end;
    logic        flag_empty, flag_full;
    logic [15:0] bus_in, bus_out;
    logic        bus_oe;

    logic [15:0] out_mem [2][MEMW];
    logic [15:0] in_mem  [2][MEMW];
    int out_tot [2];
    int out_rd  [2];
    int in_cnt  [2];
    int pe_cnt  [2];
    int pe_at   [2];
    int first_rd[2];
    int last_wr [2];
    bit stall   [2];
    int stall_pct = 0;
    int cyc = 0;
    int err_rd = 0, err_wr = 0, err_oe = 0, err_drv = 0, err_set = 0;
    logic       prev_oe = 1'b0;
    logic [1:0] prev_sel = 2'b00;
    int checks = 0, fails = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    usb_fifo_echo i_usb_fifo_echo (
        .clk(clk), .rst_n(rst_n), .ep_sel(ep_sel), .rd_stb(rd_stb), .wr_stb(wr_stb),
        .oe_stb(oe_stb), .pkt_end(pkt_end), .flag_empty(flag_empty), .flag_full(flag_full),
        .bus_in(bus_in), .bus_out(bus_out), .bus_oe(bus_oe)
    );

    // Bridge model: flags describe the addressed endpoint
    assign flag_empty = ep_sel[1] ? 1'b0 : (out_tot[ep_sel[0]] == out_rd[ep_sel[0]]);
    assign flag_full  = ep_sel[1] ? stall[ep_sel[0]] : 1'b0;
    assign bus_in     = (!ep_sel[1] && oe_stb) ? out_mem[ep_sel[0]][out_rd[ep_sel[0]] % MEMW] : 16'h0000;

    always @(negedge clk) begin
        for (int i = 0; i < 2; i++) stall[i] <= (int'($urandom_range(99)) < stall_pct);
    end

    always @(posedge clk) begin
        if (rst_n) begin
            cyc <= cyc + 1;
            if (rd_stb) begin
                if (ep_sel[1] || flag_empty) err_rd <= err_rd + 1;
                else begin
                    out_rd[ep_sel[0]] <= out_rd[ep_sel[0]] + 1;
                    if (first_rd[ep_sel[0]] < 0) first_rd[ep_sel[0]] <= cyc;
                end
                if (!prev_oe) err_oe <= err_oe + 1;
            end
            if (wr_stb) begin
                if (!ep_sel[1] || stall[ep_sel[0]]) err_wr <= err_wr + 1;
                else begin
                    in_mem[ep_sel[0]][in_cnt[ep_sel[0]] % MEMW] <= bus_out;
                    in_cnt[ep_sel[0]] <= in_cnt[ep_sel[0]] + 1;
                    last_wr[ep_sel[0]] <= cyc;
                end
            end
            if (bus_oe != wr_stb) err_drv <= err_drv + 1;
            if (ep_sel != prev_sel && (rd_stb || wr_stb || oe_stb || pkt_end)) err_set <= err_set + 1;
            if (pkt_end) begin
                if (!ep_sel[1]) err_set <= err_set + 1;
                else begin
                    pe_cnt[ep_sel[0]] <= pe_cnt[ep_sel[0]] + 1;
                    pe_at[ep_sel[0]]  <= in_cnt[ep_sel[0]];
                end
            end
        end
        prev_oe  <= oe_stb;
        prev_sel <= ep_sel;
    end

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic bit pulse_expected(input int n);
        return (n > 0) && (n < DEPTH);
    endfunction

    task automatic run_round(input int n0, input int n1);
        int n[2];
        int obase[2], ibase[2], pbase[2];
        int waited, bad, first_bad_a, first_bad_e;
        n[0] = n0; n[1] = n1;
        @(negedge clk);
        for (int c = 0; c < 2; c++) begin
            obase[c] = out_tot[c];
            ibase[c] = in_cnt[c];
            pbase[c] = pe_cnt[c];
            first_rd[c] = -1;
            last_wr[c]  = -1;
            for (int i = 0; i < n[c]; i++) out_mem[c][(out_tot[c] + i) % MEMW] = 16'($urandom);
        end
        for (int c = 0; c < 2; c++) out_tot[c] = out_tot[c] + n[c];
        waited = 0;
        while (((in_cnt[0] - ibase[0]) < n[0] || (in_cnt[1] - ibase[1]) < n[1]) && waited < 6000) begin
            @(negedge clk);
            waited++;
        end
        repeat (8) @(negedge clk);
        for (int c = 0; c < 2; c++) begin
            // R7: same word count and same words in the same order
            chk((in_cnt[c] - ibase[c]) == n[c], (n[c] == DEPTH) ? "R2" : "R7", "echoed word count",
                in_cnt[c] - ibase[c], n[c]);
            bad = 0; first_bad_a = 0; first_bad_e = 0;
            for (int i = 0; i < n[c]; i++) begin
                if (in_mem[c][(ibase[c] + i) % MEMW] !== out_mem[c][(obase[c] + i) % MEMW]) begin
                    if (bad == 0) begin
                        first_bad_a = int'(in_mem[c][(ibase[c] + i) % MEMW]);
                        first_bad_e = int'(out_mem[c][(obase[c] + i) % MEMW]);
                    end
                    bad++;
                end
            end
            chk(bad == 0, "R7", "echoed word value", first_bad_a, first_bad_e);
            // R9: exactly one commit pulse for a short packet, none otherwise
            chk((pe_cnt[c] - pbase[c]) == int'(pulse_expected(n[c])), (n[c] == DEPTH) ? "R2" : "R9",
                "packet-end pulses", pe_cnt[c] - pbase[c], int'(pulse_expected(n[c])));
            if (pulse_expected(n[c]))
                chk(pe_at[c] == in_cnt[c], "R9", "words written before packet-end", pe_at[c], in_cnt[c]);
        end
        // R10: one packet at a time when both channels hold data
        if (n0 > 0 && n1 > 0)
            chk((first_rd[1] > last_wr[0]) || (first_rd[0] > last_wr[1]), "R10", "packet overlap",
                first_rd[1], last_wr[0]);
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        chk(1'b0, "R10", "watchdog expired", cyc, 0);
        finish_run();
    end

    initial begin
        void'($urandom(32'h5EED));
        for (int c = 0; c < 2; c++) begin
            out_tot[c] = 0; out_rd[c] = 0; in_cnt[c] = 0;
            pe_cnt[c] = 0; pe_at[c] = 0; first_rd[c] = -1; last_wr[c] = -1;
        end
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(ep_sel == 2'b00, "R1", "endpoint select in reset", int'(ep_sel), 0);
        chk({rd_stb, wr_stb, oe_stb, pkt_end, bus_oe} == 5'b0, "R1", "strobes in reset",
            int'({rd_stb, wr_stb, oe_stb, pkt_end, bus_oe}), 0);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);

        // Directed corners
        stall_pct = 0;  run_round(1, 1);
        stall_pct = 30; run_round(DEPTH, DEPTH - 1);
        stall_pct = 20; run_round(0, 5);
        stall_pct = 50; run_round(3, 0);
        stall_pct = 10; run_round(DEPTH, DEPTH);
        stall_pct = 40; run_round(2, 200);
        stall_pct = 0;  run_round(0, 0);

        // Constrained random rounds
        for (int r = 0; r < 12; r++) begin
            int a, b;
            a = int'($urandom_range(DEPTH));
            b = int'($urandom_range(DEPTH));
            if (r % 4 == 0) a = DEPTH;
            if (r % 5 == 1) b = 1;
            stall_pct = int'($urandom_range(60));
            run_round(a, b);
        end

        // Port-level protocol monitors
        chk(err_rd  == 0, "R3", "reads while empty or not OUT", err_rd, 0);
        chk(err_oe  == 0, "R4", "reads without prior output-enable", err_oe, 0);
        chk(err_wr  == 0, "R5", "writes while full or not IN", err_wr, 0);
        chk(err_drv == 0, "R6", "drive enable differs from write", err_drv, 0);
        chk(err_set == 0, "R8", "strobes on address change", err_set, 0);
        finish_run();
    end

endmodule